// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Counter

A small counter stage that can be preset from a parallel word, cleared, and chained with identical stages into a wider counter that still advances on a single shared clock edge. Each stage has two count enables. A common enable (P) goes to every stage. A chained enable (T) goes to the first stage from outside, and each later stage takes its T from the carry of the stage below it. Because the carry is decoded combinationally from the stage's own count and T, a carry ripples through the whole chain within one clock period. No extra gating is needed between stages.

Two build-time parameters select the variant. `ASYNC_CLR` chooses a clear that acts at once, or a clear that is sampled on the rising edge. `DECADE` chooses binary counting (terminal count 15) or decade counting (terminal count 9). The control inputs resolve in a fixed order: clear first, then load, then count, then hold. P and T are looked at only on the rising edge, so they may change at any point in the clock period.

Top module: `presettable_counter`

## Requirements
- R1: While clear_n is low at a rising edge, the count is 0 after that edge in both variants.
- R2: With ASYNC_CLR=1, a low clear_n forces the count to 0 at once, even in the middle of a clock period, regardless of load and the enables.
- R3: With clear_n high and load_n low, the count takes the value of `preset` after the next rising edge, whatever en_p and en_t are.
- R4: Clear takes priority over load: when both are low at an edge, the count becomes 0.
- R5: With clear_n and load_n high, the count advances by one only when en_p and en_t are both 1 at the edge; otherwise it holds its value.
- R6: In binary mode (DECADE=0) the count wraps from 15 to 0.
- R7: In decade mode (DECADE=1) the count runs 0 to 9 and wraps from 9 to 0.
- R8: In decade mode, a count of 10 to 15 (reachable only by loading) goes to 0 on the next enabled count.
- R9: The carry is 1 exactly when en_t is 1 and the count equals the terminal count (15 binary, 9 decade). It does not depend on en_p.
- R10: Two binary stages, where the low stage's carry drives the high stage's en_t and en_p is shared, count as one 8-bit counter modulo 256.
- R11: After clear, the count is 0 and the carry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low clear; sampled on the edge or acting at once, depending on ASYNC_CLR |
| load_n | input | 1 | Active-low parallel preset strobe |
| preset | input | WIDTH | Value loaded when load_n is low |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable that also gates the carry; chained from the stage below |
| count | output | WIDTH | Current count |
| carry | output | 1 | High at terminal count while en_t is high |

## Verification
The bench goes after the carry seen with P held low. A design that mixed P into the carry would stall a cascade whenever the common enable dropped at a terminal count. It drives clear and load low together: a design with the priority reversed would show the preset word instead of zero. In decade mode it loads each of the values 10 to 15 and then counts. A next-state rule that only tests for equality with 9 would walk through the upper codes, or stay in them, instead of returning to 0. It runs the two cascaded stages across 15→16 and 255→0, which exposes a carry that arrives one cycle late. It also pulls the asynchronous clear low halfway through a clock-high phase: a design that only samples clear on the edge would keep a nonzero count until the next edge.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  // Operation chosen for the next rising edge, highest priority last.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_ctrl.sv
// Resolves the control inputs into one operation for the next edge.
module ctr_ctrl
  import ctr_pkg::*;
(
  input  logic    clear_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output ctr_op_e op
);
  always_comb begin
    if (!clear_n)          op = OP_CLEAR;
    else if (!load_n)      op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_step.sv
// Successor value and terminal-count decode for one stage.
module ctr_step #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] succ,
  output logic             at_term
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  // Any code at or beyond the terminal count returns to zero.
  always_comb begin
    if (cur >= TERM) succ = '0;
    else             succ = cur + 1'b1;
    at_term = (cur == TERM);
  end
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  ctr_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic [WIDTH-1:0] succ;
  logic             at_term;

  ctr_ctrl u_ctrl (
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_p    (en_p),
    .en_t    (en_t),
    .op      (op)
  );

  ctr_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
    .cur     (cnt_q),
    .succ    (succ),
    .at_term (at_term)
  );

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = preset;
      OP_COUNT: cnt_d = succ;
      default:  cnt_d = cnt_q;
    endcase
  end

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) cnt_q <= '0;
        else          cnt_q <= cnt_d;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
      end
    end
  endgenerate

  // Look-ahead carry: gated by the chained enable only.
  assign carry = en_t & at_term;
  assign count = cnt_q;
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int WIDTH     = 4,
  parameter bit DECADE    = 1'b0,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clear_n,
  input logic             load_n,
  input logic [WIDTH-1:0] preset,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] count,
  input logic             carry
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic armed = 1'b0;
  logic prev_clr_low = 1'b0;
  always_ff @(posedge clk) begin
    armed        <= 1'b1;
    prev_clr_low <= !clear_n;
  end

  assert_clear_R1: assert property (@(posedge clk)
    (armed && prev_clr_low) |-> (count == '0));

  generate
    if (ASYNC_CLR) begin : g_async_chk
      assert_async_zero_R2: assert property (@(negedge clk)
        !clear_n |-> (count == '0));
    end
  endgenerate

  assert_load_R3: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> (count == $past(preset)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_p && en_t)) |=> $stable(count));

  assert_wrap_R6_R8: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_p && en_t && count >= TERM) |=> (count == '0));

  assert_carry_t_R9: assert property (@(posedge clk) disable iff (!clear_n)
    carry |-> (en_t && count == TERM));

  assert_carry_set_R9: assert property (@(posedge clk) disable iff (!clear_n)
    (en_t && count == TERM) |-> carry);
endmodule

bind presettable_counter ctr_checker #(
  .WIDTH(WIDTH), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)
) u_chk (
  .clk(clk), .clear_n(clear_n), .load_n(load_n), .preset(preset),
  .en_p(en_p), .en_t(en_t), .count(count), .carry(carry)
);

// File: tb/sim_presettable_counter.sv
`timescale 1ns/1ps
module sim_presettable_counter;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  // Cascade (binary, synchronous clear)
  logic       clr_n, ld_n, p, t;
  logic [7:0] din;
  logic [3:0] q0, q1;
  logic       c0, c1;
  // Decade stage (asynchronous clear)
  logic       clr2_n, ld2_n, p2, t2;
  logic [3:0] din2, q2;
  logic       c2;

  presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .clear_n(clr_n), .load_n(ld_n), .preset(din[3:0]),
    .en_p(p), .en_t(t), .count(q0), .carry(c0));
  presettable_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u1 (
    .clk(clk), .clear_n(clr_n), .load_n(ld_n), .preset(din[7:4]),
    .en_p(p), .en_t(c0), .count(q1), .carry(c1));
  presettable_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u2 (
    .clk(clk), .clear_n(clr2_n), .load_n(ld2_n), .preset(din2),
    .en_p(p2), .en_t(t2), .count(q2), .carry(c2));

  int checks = 0;
  int errors = 0;
  int cnt8 = 0;
  int m2 = 0;
  string phase = "R11";
  bit done = 1'b0;

  // Behavioural reference model
  always @(posedge clk) begin
    if (!clr_n)       cnt8 = 0;
    else if (!ld_n)   cnt8 = int'(din);
    else if (p && t)  cnt8 = (cnt8 + 1) % 256;
    if (!clr2_n)      m2 = 0;
    else if (!ld2_n)  m2 = int'(din2);
    else if (p2 && t2) m2 = (m2 >= 9) ? 0 : m2 + 1;
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    check(phase, "cascade count", int'({q1, q0}), cnt8);
    check(phase, "carry low stage", int'(c0), int'(t && (cnt8 % 16 == 15)));
    check(phase, "carry high stage", int'(c1), int'(t && cnt8 == 255));
    check(phase, "decade count", int'(q2), m2);
    check(phase, "decade carry", int'(c2), int'(t2 && m2 == 9));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  initial begin
    clr_n = 1'b0; ld_n = 1'b1; p = 1'b0; t = 1'b1; din = '0;
    clr2_n = 1'b0; ld2_n = 1'b1; p2 = 1'b0; t2 = 1'b1; din2 = '0;
    repeat (2) @(posedge clk);
    phase = "R11"; cyc(1);
    clr_n = 1'b1; clr2_n = 1'b1;
    // R5: count only with both enables
    phase = "R5"; p = 1'b0; t = 1'b1; cyc(3);
    p = 1'b1; t = 1'b0; cyc(3);
    // R10: cascade crosses the low-stage carry
    phase = "R10"; p = 1'b1; t = 1'b1; cyc(40);
    // R9: carry with P low
    phase = "R9"; ld_n = 1'b0; din = 8'h0F; p = 1'b0; t = 1'b1; cyc(1);
    ld_n = 1'b1; cyc(2);
    t = 1'b0; cyc(1);
    // R3: load overrides enables
    phase = "R3"; ld_n = 1'b0; din = 8'hA5; p = 1'b0; t = 1'b0; cyc(1);
    din = 8'h3C; p = 1'b1; t = 1'b1; cyc(1);
    ld_n = 1'b1; cyc(2);
    // R6 and R10: wrap 255 -> 0
    phase = "R6"; ld_n = 1'b0; din = 8'hFC; cyc(1);
    ld_n = 1'b1; cyc(6);
    // R1: synchronous clear while counting
    phase = "R1"; clr_n = 1'b0; cyc(2);
    clr_n = 1'b1; cyc(2);
    // R4: clear beats load
    phase = "R4"; ld_n = 1'b0; din = 8'h77; clr_n = 1'b0; cyc(1);
    clr_n = 1'b1; cyc(1);
    ld_n = 1'b1; cyc(1);
    // R7: decade run through 9 -> 0
    phase = "R7"; ld2_n = 1'b0; din2 = 4'd7; cyc(1);
    ld2_n = 1'b1; p2 = 1'b1; t2 = 1'b1; cyc(12);
    phase = "R9"; ld2_n = 1'b0; din2 = 4'd9; cyc(1);
    ld2_n = 1'b1; p2 = 1'b0; cyc(2);
    // R8: illegal decade codes return to zero
    phase = "R8";
    for (int v = 10; v < 16; v++) begin
      ld2_n = 1'b0; din2 = 4'(v); p2 = 1'b1; cyc(1);
      ld2_n = 1'b1; cyc(2);
    end
    // R2: asynchronous clear mid-period
    phase = "R2"; ld2_n = 1'b0; din2 = 4'd6; cyc(1);
    ld2_n = 1'b1; cyc(1);
    @(posedge clk); #1;
    clr2_n = 1'b0; #0.5;
    m2 = 0;
    check("R2", "async clear immediate", int'(q2), 0);
    cyc(1);
    clr2_n = 1'b1; cyc(3);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule